// File: doc/BRIEF.md
# PLL Lock Bring-Up Sequencer

This block takes a transmit PHY's PLL from reset to locked and then to PHY-ready. A start pulse begins a fixed burst of control-register writes. The block then checks five status bits in a strict order. Each bit is sampled at a fixed interval and has its own timeout.

The first stage that times out ends the run. The block reports an error code naming that stage, raises a one-cycle done pulse and leaves the locked flag low. If all five stages pass, the block sets the locked flag and pulses done with a zero error code.

A disable command is accepted at any time. It abandons the run, clears the locked flag, releases the power-rail request and issues a power-down write. When the top link rate is selected, a rail request is raised together with the first write of the run.

Top module: `pll_lock_seq`

## Requirements
- R1: While reset is held and after its release, `wr_valid_o`, `locked_o`, `done_o` and `rail_req_o` are 0 and `err_o` is 0.
- R2: A start pulse accepted in idle, with no disable in that cycle, is followed in the next five consecutive cycles by these writes, one per cycle, in this order: config 0x01, config 0x05, config 0x01, config 0x09, reset-control 0x20. The `wr_sel_o` encoding is 0 for config, 1 for reset-control and 2 for power-down.
- R3: The first three stages are, in order, calibration ready (stage code 1), frequency done (code 2) and PLL locked (code 3). Only the bit of the current stage can advance the run.
- R4: When the PLL-locked stage passes, exactly one config write of 0x19 follows in the next cycle. The run then waits for transmit sync done (code 4) and then PHY ready (code 5).
- R5: In each stage, the status bit is sampled in the cycle the stage is entered and then every `POLL_CYC` cycles. A bit that is high only between samples is not seen.
- R6: A stage fails if its bit is still low at the sample taken `TIMEOUT_CYC` cycles after stage entry. On failure, `err_o` takes the stage code, `done_o` pulses for one cycle, `locked_o` stays 0 and no later stage is attempted.
- R7: When all five stages pass, `locked_o` rises and `done_o` pulses for one cycle, with `err_o` equal to 0.
- R8: Accepting a start clears `locked_o` and `err_o` on the next cycle.
- R9: A disable in any cycle produces, in the next cycle, a power-down write of 0x02 with `locked_o` = 0 and `rail_req_o` = 0. It abandons any run in progress without a done pulse.
- R10: `rail_req_o` follows `high_rate_i` at the accepted start and stays at that value until the next accepted start or a disable.
- R11: A start while a run is in progress is ignored. A disable and a start in the same cycle act as a disable alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bring-up run (pulse) |
| disable_i | input | 1 | Power down and abandon the run |
| high_rate_i | input | 1 | Top link rate selected; request the extra rail |
| cal_ready_i | input | 1 | Calibration ready status |
| freq_done_i | input | 1 | Frequency search done status |
| pll_lock_i | input | 1 | PLL locked status |
| tsync_done_i | input | 1 | Transmit sync done status |
| phy_ready_i | input | 1 | PHY ready status |
| wr_valid_o | output | 1 | Register write strobe |
| wr_sel_o | output | 2 | Write target: 0 config, 1 reset-control, 2 power-down |
| wr_data_o | output | 8 | Write data |
| locked_o | output | 1 | Bring-up completed successfully |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 3 | Failing stage code, 0 if none |
| rail_req_o | output | 1 | Extra power-rail request |

## Verification
Disable can land in the same cycle as a start, or in the same cycle as the final PHY-ready sample that would otherwise complete the run. The bench places a disable in exactly the cycle where a start is accepted. It also counts cycles from a start with all status bits high and places a disable on the edge where the last stage passes. In both cases the cycle-accurate model expects the power-down write, no done pulse, the locked flag low and the rail request released. The design's outputs are compared against that model on every clock.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_RSTSM = 2'd1,
    SEL_PWRDN = 2'd2
  } wr_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_POLL,
    ST_PHYW
  } seq_st_e;

  localparam int NUM_STAGES = 5;
  localparam int NUM_INIT   = 5;
  localparam int STG_W      = $clog2(NUM_STAGES + 1);
  localparam int INIT_W     = $clog2(NUM_INIT);
  localparam int LOCK_STAGE = 2;
  localparam logic [7:0] CFG_PHY_GO = 8'h19;
  localparam logic [7:0] PWRDN_VAL  = 8'h02;
endpackage

// File: rtl/init_rom.sv
module init_rom
  import pll_seq_pkg::*;
(
  input  logic [INIT_W-1:0] idx_i,
  output logic [1:0]        sel_o,
  output logic [7:0]        data_o
);
  always_comb begin
    sel_o  = SEL_CFG;
    data_o = 8'h00;
    case (idx_i)
      3'd0: data_o = 8'h01;
      3'd1: data_o = 8'h05;
      3'd2: data_o = 8'h01;
      3'd3: data_o = 8'h09;
      3'd4: begin sel_o = SEL_RSTSM; data_o = 8'h20; end
      default: data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/stat_sel.sv
module stat_sel
  import pll_seq_pkg::*;
(
  input  logic [NUM_STAGES-1:0] stat_i,
  input  logic [STG_W-1:0]      idx_i,
  output logic                  hit_o
);
  logic [NUM_STAGES-1:0] match;
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_match
    assign match[g] = stat_i[g] & (idx_i == STG_W'(g));
  end
  assign hit_o = |match;
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int POLL_CYC    = 25000,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic sample_o,
  output logic last_o
);
  localparam int MAX_TRIES = TIMEOUT_CYC / POLL_CYC;
  localparam int PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int TW = $clog2(MAX_TRIES + 1);

  logic [PW-1:0] intv_q;
  logic [TW-1:0] tries_q;

  assign sample_o = en_i && (intv_q == '0);
  assign last_o   = (tries_q == TW'(MAX_TRIES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intv_q  <= '0;
      tries_q <= '0;
    end else if (clear_i) begin
      intv_q  <= '0;
      tries_q <= '0;
    end else if (en_i) begin
      if (intv_q == '0) begin
        intv_q <= PW'(POLL_CYC - 1);
        if (!last_o) tries_q <= tries_q + 1'b1;
      end else begin
        intv_q <= intv_q - 1'b1;
      end
    end
  end

  // R6
  tries_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q <= TW'(MAX_TRIES));
  // R5
  interval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && intv_q != '0) |=> (tries_q == $past(tries_q)));
endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
  import pll_seq_pkg::*;
#(
  parameter int POLL_CYC    = 25000,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       disable_i,
  input  logic       high_rate_i,
  input  logic       cal_ready_i,
  input  logic       freq_done_i,
  input  logic       pll_lock_i,
  input  logic       tsync_done_i,
  input  logic       phy_ready_i,
  output logic       wr_valid_o,
  output logic [1:0] wr_sel_o,
  output logic [7:0] wr_data_o,
  output logic       locked_o,
  output logic       done_o,
  output logic [2:0] err_o,
  output logic       rail_req_o
);
  seq_st_e           state_q;
  logic [INIT_W-1:0] idx_q;
  logic [STG_W-1:0]  stage_q;
  logic              pd_q;
  logic              stage_hit, sample, last, in_poll, pass, fail, tmr_clear;
  logic [1:0]        rom_sel;
  logic [7:0]        rom_data;
  logic [NUM_STAGES-1:0] stat_vec;

  // stage order: bit index equals stage index
  assign stat_vec = {phy_ready_i, tsync_done_i, pll_lock_i, freq_done_i, cal_ready_i};

  stat_sel u_sel (.stat_i(stat_vec), .idx_i(stage_q), .hit_o(stage_hit));
  init_rom u_rom (.idx_i(idx_q), .sel_o(rom_sel), .data_o(rom_data));

  assign in_poll   = (state_q == ST_POLL);
  assign pass      = sample && stage_hit;
  assign fail      = sample && !stage_hit && last;
  assign tmr_clear = !in_poll || pass || disable_i;

  poll_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk_i, .rst_ni, .clear_i(tmr_clear), .en_i(in_poll),
    .sample_o(sample), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      stage_q    <= '0;
      pd_q       <= 1'b0;
      locked_o   <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= '0;
      rail_req_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      pd_q   <= disable_i;
      if (disable_i) begin
        state_q    <= ST_IDLE;
        locked_o   <= 1'b0;
        rail_req_o <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: if (start_i) begin
            state_q    <= ST_INIT;
            idx_q      <= '0;
            stage_q    <= '0;
            locked_o   <= 1'b0;
            err_o      <= '0;
            rail_req_o <= high_rate_i;
          end
          ST_INIT: begin
            if (idx_q == INIT_W'(NUM_INIT - 1)) begin
              state_q <= ST_POLL;
              stage_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_POLL: begin
            if (pass) begin
              if (stage_q == STG_W'(LOCK_STAGE)) begin
                state_q <= ST_PHYW;
              end else if (stage_q == STG_W'(NUM_STAGES - 1)) begin
                state_q  <= ST_IDLE;
                locked_o <= 1'b1;
                done_o   <= 1'b1;
              end else begin
                stage_q <= stage_q + 1'b1;
              end
            end else if (fail) begin
              state_q <= ST_IDLE;
              err_o   <= 3'(stage_q) + 3'd1;
              done_o  <= 1'b1;
            end
          end
          ST_PHYW: begin
            state_q <= ST_POLL;
            stage_q <= STG_W'(LOCK_STAGE + 1);
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    wr_valid_o = 1'b0;
    wr_sel_o   = SEL_CFG;
    wr_data_o  = 8'h00;
    if (pd_q) begin
      wr_valid_o = 1'b1;
      wr_sel_o   = SEL_PWRDN;
      wr_data_o  = PWRDN_VAL;
    end else if (state_q == ST_INIT) begin
      wr_valid_o = 1'b1;
      wr_sel_o   = rom_sel;
      wr_data_o  = rom_data;
    end else if (state_q == ST_PHYW) begin
      wr_valid_o = 1'b1;
      wr_data_o  = CFG_PHY_GO;
    end
  end

  // R2
  start_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !disable_i) |=>
      (wr_valid_o && wr_sel_o == SEL_CFG && wr_data_o == 8'h01 && !locked_o));
  // R9
  disable_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> (wr_valid_o && wr_sel_o == SEL_PWRDN && wr_data_o == PWRDN_VAL
                   && !locked_o && !rail_req_o && !done_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (locked_o == (err_o == 3'd0)));
  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL && start_i && !disable_i && !pass && !fail) |=>
      (state_q == ST_POLL && $stable(stage_q)));
  // R4
  phy_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PHYW && !disable_i) |=> (in_poll && stage_q == STG_W'(LOCK_STAGE + 1)));
endmodule

// File: tb/pll_lock_seq_tb.sv
module pll_lock_seq_tb_top;
  localparam int P = 4;
  localparam int T = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, disable_i = 1'b0, high_rate_i = 1'b0;
  logic [4:0] stat = 5'b0;
  logic wr_valid_o, locked_o, done_o, rail_req_o;
  logic [1:0] wr_sel_o;
  logic [7:0] wr_data_o;
  logic [2:0] err_o;

  int n_chk = 0, n_fail = 0;
  int done_seen = 0;
  bit saw_go = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  pll_lock_seq #(.POLL_CYC(P), .TIMEOUT_CYC(T)) dut_i (
    .clk_i, .rst_ni, .start_i, .disable_i, .high_rate_i,
    .cal_ready_i(stat[0]), .freq_done_i(stat[1]), .pll_lock_i(stat[2]),
    .tsync_done_i(stat[3]), .phy_ready_i(stat[4]),
    .wr_valid_o, .wr_sel_o, .wr_data_o, .locked_o, .done_o, .err_o, .rail_req_o
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int q[$];
  bit m_busy, m_pd, m_locked, m_done, m_rail;
  int m_stage, m_t, m_err;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      q.delete(); m_busy = 0; m_pd = 0; m_locked = 0; m_done = 0;
      m_rail = 0; m_stage = 0; m_t = 0; m_err = 0;
    end else begin
      m_done = 0;
      m_pd = disable_i;
      if (disable_i) begin
        q.delete(); m_busy = 0; m_locked = 0; m_rail = 0;
      end else if (!m_busy) begin
        if (start_i) begin
          m_busy = 1; m_locked = 0; m_err = 0; m_rail = high_rate_i;
          m_stage = 0; m_t = 0;
          q = '{8'h01, 8'h05, 8'h01, 8'h09, 256 + 8'h20};
        end
      end else if (q.size() > 0) begin
        void'(q.pop_front());
        m_t = 0;
      end else begin
        if ((m_t % P) == 0 && stat[m_stage]) begin
          m_t = 0;
          if (m_stage == 2) begin q.push_back(8'h19); m_stage = 3; end
          else if (m_stage == 4) begin m_busy = 0; m_locked = 1; m_done = 1; end
          else m_stage++;
        end else if (m_t == T) begin
          m_busy = 0; m_err = m_stage + 1; m_done = 1;
        end else m_t++;
      end
    end
  end

  initial forever begin
    @(posedge clk_i); #5;
    if (rst_ni) begin
      bit ev; int ew;
      ev = m_pd || (m_busy && q.size() > 0);
      ew = m_pd ? (2 * 256 + 2) : (ev ? q[0] : 0);
      chk("R2 wr_valid", wr_valid_o, ev);
      if (ev && wr_valid_o) chk("R2 write", {wr_sel_o, wr_data_o}, ew);
      chk("R7 locked", locked_o, m_locked);
      chk("R6 done", done_o, m_done);
      chk("R6 err", err_o, m_err);
      chk("R10 rail", rail_req_o, m_rail);
      if (done_o) done_seen++;
      if (wr_valid_o && wr_sel_o == 2'd0 && wr_data_o == 8'h19) saw_go = 1;
    end
  end

  task automatic do_start(bit hr);
    @(negedge clk_i); start_i = 1; high_rate_i = hr;
    @(negedge clk_i); start_i = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(posedge clk_i); #6; n++; end while (!done_o && n < 300);
    chk("R6 done reached", done_o, 1);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 outputs during reset
    chk("R1 valid", wr_valid_o, 0); chk("R1 locked", locked_o, 0);
    chk("R1 done", done_o, 0); chk("R1 err", err_o, 0); chk("R1 rail", rail_req_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle valid", wr_valid_o, 0);

    // R7 R10 full pass at high rate
    stat = 5'b11111; saw_go = 0;
    do_start(1);
    wait_done();
    chk("R7 locked", locked_o, 1); chk("R7 err", err_o, 0);
    chk("R10 rail held", rail_req_o, 1); chk("R4 go write seen", saw_go, 1);

    // R8 locked cleared at start; R6 timeout stage 1
    stat = 5'b0;
    do_start(0);
    chk("R8 locked cleared", locked_o, 0);
    // R11 start while busy is ignored
    repeat (8) @(negedge clk_i);
    start_i = 1; @(negedge clk_i); start_i = 0;
    chk("R11 no restart write", wr_valid_o, 0);
    wait_done();
    chk("R6 err cal", err_o, 1); chk("R6 locked low", locked_o, 0);

    // R3 later bits do not advance stage 1
    stat = 5'b11110;
    do_start(0); wait_done();
    chk("R3 err cal", err_o, 1);
    stat = 5'b00001;
    do_start(0); wait_done();
    chk("R3 err freq", err_o, 2);
    stat = 5'b00011;
    do_start(0); wait_done();
    chk("R3 err lock", err_o, 3);

    // R4 phy stages
    stat = 5'b00111; saw_go = 0;
    do_start(0); wait_done();
    chk("R4 err tsync", err_o, 4); chk("R4 go write", saw_go, 1);
    stat = 5'b01111;
    do_start(0); wait_done();
    chk("R4 err phy", err_o, 5);

    // R5 glitch between samples is missed
    stat = 5'b0;
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    repeat (6) @(negedge clk_i);
    stat = 5'b00001;
    @(negedge clk_i); stat = 5'b0;
    wait_done();
    chk("R5 glitch unseen", err_o, 1);
    // R5 bit raised late is picked up at a later sample
    stat = 5'b0;
    do_start(0);
    repeat (9) @(negedge clk_i);
    stat = 5'b11111;
    wait_done();
    chk("R5 late pass", err_o, 0); chk("R5 late locked", locked_o, 1);

    // R9 disable mid run
    stat = 5'b00001;
    done_seen = 0;
    do_start(1);
    repeat (7) @(negedge clk_i);
    disable_i = 1; @(negedge clk_i); disable_i = 0;
    chk("R9 pd write", {wr_valid_o, wr_sel_o, wr_data_o}, {1'b1, 2'd2, 8'h02});
    chk("R9 rail off", rail_req_o, 0); chk("R9 locked", locked_o, 0);
    repeat (30) @(negedge clk_i);
    chk("R9 no done", done_seen, 0);

    // R11 disable with start same cycle
    @(negedge clk_i); start_i = 1; disable_i = 1;
    @(negedge clk_i); start_i = 0; disable_i = 0;
    chk("R11 pd wins", {wr_valid_o, wr_sel_o}, {1'b1, 2'd2});
    @(negedge clk_i);
    chk("R11 no run", wr_valid_o, 0);

    // R9 disable on the final pass edge
    stat = 5'b11111; done_seen = 0;
    @(negedge clk_i); start_i = 1; high_rate_i = 1;
    @(negedge clk_i); start_i = 0;
    repeat (10) @(negedge clk_i);
    disable_i = 1; @(negedge clk_i); disable_i = 0;
    chk("R9 final locked", locked_o, 0); chk("R9 final rail", rail_req_o, 0);
    repeat (5) @(negedge clk_i);
    chk("R9 final no done", done_seen, 0);

    // R10 low rate keeps rail off
    do_start(0); wait_done();
    chk("R10 rail low", rail_req_o, 0); chk("R7 relock", locked_o, 1);

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule